// File: doc/BRIEF.md
# Interrupt source state controller

This block keeps the per-source state of an interrupt controller's source layer and hands interrupts, one at a time, to a presentation layer that decides whether to take them. It has a fixed number of sources. Each source has a parameter-chosen type, either level or message. For each source the block holds a target server, a priority, a saved priority and four status bits: asserted, sent, rejected and masked-pending.

The presentation layer sees one offer at a time, made of a global interrupt number, a priority and a server, on a valid/ready channel. The global number is the local source index plus a base offset. When the presentation layer turns an interrupt away it sends a reject, and when service completes it sends an EOI. Both carry the global number. A resend request starts a walk over all sources, one per cycle, which re-offers anything rejected or still asserted and unsent. A priority of 0xFF masks a source. A message arriving for a masked source is kept as masked-pending and is replayed when a configuration write unmasks it.

A side port returns the stored fields and status of any one source, for observation.

Top module: `irq_source_ctl`

## Requirements
- R1: After reset every source has priority 0xFF, saved priority 0xFF, server 0 and all status bits clear, and there is no offer and no scan in progress. Source types are unaffected by reset. The status word on the side port is {masked-pending, rejected, sent, asserted} in bits 3 down to 0.
- R2: An offer never carries priority 0xFF. A source whose priority is 0xFF is never offered.
- R3: For a message-type source, each cycle with its line bit high is one message. If the source is masked the message sets masked-pending; otherwise the source is queued for an offer.
- R4: For a level-type source, a change of the line updates asserted to the new line value. The source is then queued, and sent is set, only if it is unmasked, asserted and not sent. A level that is held steady alone causes no further offer.
- R5: A configuration write stores server, priority and saved priority. For a message source with masked-pending set and a new priority other than 0xFF, the write clears masked-pending and queues the source. For a level source it applies the R4 offer check. Writing 0xFF to a queued source cancels it: a message source returns to masked-pending and a level source clears sent.
- R6: A reject whose number lies in [BASE, BASE+N) sets rejected and clears sent for that source. Numbers outside that range change nothing.
- R7: An EOI clears sent for a level source. It has no effect on a message source.
- R8: A resend request while idle raises busy for exactly N cycles and visits source 0 to N-1, one per cycle. A visited message source with rejected set has rejected cleared and is queued if unmasked. A visited level source gets the R4 offer check. A request made while busy causes one more full walk right after the current one.
- R9: At most one offer is outstanding. It holds num, prio and server stable until ready is seen. The lowest-index queued source is launched first, one cycle after being queued, with offer_num = BASE + index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | N | Source lines: a level for level sources, a one-cycle message strobe for message sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Local index of the source being configured |
| cfg_server | input | SRV_W | Server to store |
| cfg_prio | input | 8 | Priority to store (0xFF masks) |
| cfg_saved | input | 8 | Saved priority to store |
| rej_valid | input | 1 | Reject notification strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | EOI notification strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Request a resend walk over all sources |
| resend_busy | output | 1 | Resend walk in progress |
| offer_valid | output | 1 | An offer is presented |
| offer_ready | input | 1 | Presentation layer takes the offer |
| offer_num | output | NUM_W | Global number of the offer |
| offer_prio | output | 8 | Priority of the offer |
| offer_server | output | SRV_W | Target server of the offer |
| peek_idx | input | IW | Source selected on the side port |
| peek_prio | output | 8 | Stored priority of the selected source |
| peek_saved | output | 8 | Stored saved priority of the selected source |
| peek_server | output | SRV_W | Stored server of the selected source |
| peek_status | output | 4 | {masked-pending, rejected, sent, asserted} of the selected source |

## Verification
The hardest case to reach is several events landing on one source in the same cycle while the offer channel is stalled. An example is a reject arriving while that source's line changes, or a masking write hitting a source that is already queued behind an offer not yet taken. The resend walk adds a related case: a reject or a second request can arrive after the walk has passed the index it concerns. Directed stimulus first holds ready low to build a queue, then masks a queued source and checks that it falls back to masked-pending. A long random phase follows. It toggles lines, writes configurations, sends in-range and out-of-range rejects and EOIs, and issues resend requests. A behavioural reference model is compared with the outputs and the side port on every clock.

// File: rtl/irq_source_ctl.sv
module irq_source_ctl #(
  parameter int N = 16,
  parameter int BASE = 4096,
  parameter int NUM_W = 16,
  parameter int SRV_W = 8,
  parameter logic [N-1:0] LVL_MASK = 'hF0,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     src_in,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic [7:0]       cfg_saved,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend_req,
  output logic             resend_busy,
  output logic             offer_valid,
  input  logic             offer_ready,
  output logic [NUM_W-1:0] offer_num,
  output logic [7:0]       offer_prio,
  output logic [SRV_W-1:0] offer_server,
  input  logic [IW-1:0]    peek_idx,
  output logic [7:0]       peek_prio,
  output logic [7:0]       peek_saved,
  output logic [SRV_W-1:0] peek_server,
  output logic [3:0]       peek_status
);
  localparam logic [7:0] MASKED = 8'hFF;

  logic [7:0]       prio_q  [N];
  logic [7:0]       saved_q [N];
  logic [SRV_W-1:0] srv_q   [N];
  logic [N-1:0] asrt, sent, rej, mpnd, want;
  logic [N-1:0] asrt_n, sent_n, rej_n, mpnd_n, want_n;
  logic [N-1:0] gnt;
  logic         any;
  logic [NUM_W-1:0] pick_num;
  logic [7:0]       pick_prio;
  logic [SRV_W-1:0] pick_srv;
  logic [IW-1:0] scan_idx;
  logic          again;

  wire launch = !offer_valid || offer_ready;

  always_comb begin
    any = 1'b0;
    gnt = '0;
    pick_num = '0;
    pick_prio = '0;
    pick_srv = '0;
    for (int i = 0; i < N; i++) begin
      if (want[i] && !any) begin
        any = 1'b1;
        gnt[i] = 1'b1;
        pick_num = NUM_W'(BASE + i);
        pick_prio = prio_q[i];
        pick_srv = srv_q[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic a, s, r, m, w, lvl;
      logic [7:0] p;
      lvl = LVL_MASK[i];
      a = asrt[i];
      s = sent[i];
      r = rej[i];
      m = mpnd[i];
      w = want[i] & ~(gnt[i] & launch);
      p = prio_q[i];
      if (rej_valid && rej_num == NUM_W'(BASE + i)) begin
        r = 1'b1;
        s = 1'b0;
      end
      if (eoi_valid && eoi_num == NUM_W'(BASE + i) && lvl) s = 1'b0;
      if (lvl) begin
        if (src_in[i] != a) begin
          a = src_in[i];
          if (p != MASKED && a && !s) begin s = 1'b1; w = 1'b1; end
        end
      end else if (src_in[i]) begin
        if (p == MASKED) m = 1'b1;
        else w = 1'b1;
      end
      if (cfg_we && cfg_idx == IW'(i)) begin
        p = cfg_prio;
        if (p == MASKED) begin
          if (w) begin
            w = 1'b0;
            if (lvl) s = 1'b0;
            else m = 1'b1;
          end
        end else if (lvl) begin
          if (a && !s) begin s = 1'b1; w = 1'b1; end
        end else if (m) begin
          m = 1'b0;
          w = 1'b1;
        end
      end
      if (resend_busy && scan_idx == IW'(i)) begin
        if (lvl) begin
          if (p != MASKED && a && !s) begin s = 1'b1; w = 1'b1; end
        end else if (r) begin
          r = 1'b0;
          if (p != MASKED) w = 1'b1;
        end
      end
      asrt_n[i] = a;
      sent_n[i] = s;
      rej_n[i]  = r;
      mpnd_n[i] = m;
      want_n[i] = w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        prio_q[i]  <= MASKED;
        saved_q[i] <= MASKED;
        srv_q[i]   <= '0;
      end
      asrt <= '0;
      sent <= '0;
      rej  <= '0;
      mpnd <= '0;
      want <= '0;
    end else begin
      if (cfg_we) begin
        prio_q[cfg_idx]  <= cfg_prio;
        saved_q[cfg_idx] <= cfg_saved;
        srv_q[cfg_idx]   <= cfg_server;
      end
      asrt <= asrt_n;
      sent <= sent_n;
      rej  <= rej_n;
      mpnd <= mpnd_n;
      want <= want_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offer_valid  <= 1'b0;
      offer_num    <= '0;
      offer_prio   <= '0;
      offer_server <= '0;
    end else if (launch) begin
      offer_valid <= any;
      if (any) begin
        offer_num    <= pick_num;
        offer_prio   <= pick_prio;
        offer_server <= pick_srv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resend_busy <= 1'b0;
      scan_idx    <= '0;
      again       <= 1'b0;
    end else if (resend_busy) begin
      if (scan_idx == IW'(N - 1)) begin
        scan_idx <= '0;
        again    <= 1'b0;
        if (!(again || resend_req)) resend_busy <= 1'b0;
      end else begin
        scan_idx <= scan_idx + 1'b1;
        if (resend_req) again <= 1'b1;
      end
    end else if (resend_req) begin
      resend_busy <= 1'b1;
      scan_idx    <= '0;
    end
  end

  assign peek_prio   = prio_q[peek_idx];
  assign peek_saved  = saved_q[peek_idx];
  assign peek_server = srv_q[peek_idx];
  assign peek_status = {mpnd[peek_idx], rej[peek_idx], sent[peek_idx], asrt[peek_idx]};
endmodule

// File: rtl/irq_source_ctl_chk.sv
module irq_source_ctl_chk #(
  parameter int N = 16,
  parameter int BASE = 4096,
  parameter int NUM_W = 16,
  parameter int SRV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             resend_req,
  input logic             resend_busy,
  input logic             offer_valid,
  input logic             offer_ready,
  input logic [NUM_W-1:0] offer_num,
  input logic [7:0]       offer_prio,
  input logic [SRV_W-1:0] offer_server
);
  p_never_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> offer_prio != 8'hFF);

  p_offer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && !offer_ready |=> offer_valid && $stable(offer_num)
      && $stable(offer_prio) && $stable(offer_server));

  p_num_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> offer_num >= NUM_W'(BASE) && offer_num <= NUM_W'(BASE + N - 1));

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resend_busy) |-> $past(resend_req));
endmodule

bind irq_source_ctl irq_source_ctl_chk #(
  .N(N), .BASE(BASE), .NUM_W(NUM_W), .SRV_W(SRV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .resend_req(resend_req), .resend_busy(resend_busy),
  .offer_valid(offer_valid), .offer_ready(offer_ready), .offer_num(offer_num),
  .offer_prio(offer_prio), .offer_server(offer_server)
);

// File: tb/irq_source_ctl_test.sv
module irq_source_ctl_test;
  localparam int N = 16;
  localparam int BASE = 4096;
  localparam int NUM_W = 16;
  localparam int SRV_W = 8;
  localparam int IW = 4;
  localparam logic [N-1:0] LVL = 16'h00F0;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_in = '0;
  logic cfg_we = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [SRV_W-1:0] cfg_server = '0;
  logic [7:0] cfg_prio = '0, cfg_saved = '0;
  logic rej_valid = 0, eoi_valid = 0, resend_req = 0, offer_ready = 1;
  logic [NUM_W-1:0] rej_num = '0, eoi_num = '0;
  logic [IW-1:0] peek_idx = '0;
  logic resend_busy, offer_valid;
  logic [NUM_W-1:0] offer_num;
  logic [7:0] offer_prio, peek_prio, peek_saved;
  logic [SRV_W-1:0] offer_server, peek_server;
  logic [3:0] peek_status;

  irq_source_ctl #(.N(N), .BASE(BASE), .NUM_W(NUM_W), .SRV_W(SRV_W), .LVL_MASK(LVL)) uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_req(resend_req), .resend_busy(resend_busy), .offer_valid(offer_valid),
    .offer_ready(offer_ready), .offer_num(offer_num), .offer_prio(offer_prio),
    .offer_server(offer_server), .peek_idx(peek_idx), .peek_prio(peek_prio),
    .peek_saved(peek_saved), .peek_server(peek_server), .peek_status(peek_status));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic hc(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int mp[N], ms[N], msrv[N];
  bit ma[N], mst[N], mr[N], mm[N], mw[N];
  bit m_ov, m_busy, m_again;
  int m_num, m_prio, m_srv, m_idx;

  function automatic void lcheck(int i);
    if (mp[i] != 255 && ma[i] && !mst[i]) begin mst[i] = 1; mw[i] = 1; end
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      mp[i] = 255; ms[i] = 255; msrv[i] = 0;
      ma[i] = 0; mst[i] = 0; mr[i] = 0; mm[i] = 0; mw[i] = 0;
    end
    m_ov = 0; m_num = 0; m_prio = 0; m_srv = 0;
    m_busy = 0; m_again = 0; m_idx = 0;
  endtask

  task automatic model_step();
    bit launch;
    int g;
    launch = !m_ov || offer_ready;
    g = -1;
    for (int i = 0; i < N; i++) if (launch && mw[i] && g < 0) g = i;
    if (launch) begin
      m_ov = (g >= 0);
      if (g >= 0) begin
        m_num = BASE + g; m_prio = mp[g]; m_srv = msrv[g]; mw[g] = 0;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (rej_valid && int'(rej_num) == BASE + i) begin mr[i] = 1; mst[i] = 0; end
      if (eoi_valid && int'(eoi_num) == BASE + i && LVL[i]) mst[i] = 0;
      if (LVL[i]) begin
        if (src_in[i] != ma[i]) begin ma[i] = src_in[i]; lcheck(i); end
      end else if (src_in[i]) begin
        if (mp[i] == 255) mm[i] = 1; else mw[i] = 1;
      end
      if (cfg_we && int'(cfg_idx) == i) begin
        mp[i] = cfg_prio; ms[i] = cfg_saved; msrv[i] = cfg_server;
        if (mp[i] == 255) begin
          if (mw[i]) begin mw[i] = 0; if (LVL[i]) mst[i] = 0; else mm[i] = 1; end
        end else if (LVL[i]) lcheck(i);
        else if (mm[i]) begin mm[i] = 0; mw[i] = 1; end
      end
      if (m_busy && m_idx == i) begin
        if (LVL[i]) lcheck(i);
        else if (mr[i]) begin mr[i] = 0; if (mp[i] != 255) mw[i] = 1; end
      end
    end
    if (m_busy) begin
      if (m_idx == N - 1) begin
        if (m_again || resend_req) begin m_idx = 0; m_again = 0; end
        else m_busy = 0;
      end else begin
        m_idx++;
        if (resend_req) m_again = 1;
      end
    end else if (resend_req) begin
      m_busy = 1; m_idx = 0;
    end
  endtask

  task automatic compare();
    int k;
    k = int'(peek_idx);
    hc("R9 offer_valid", offer_valid, m_ov);
    if (m_ov) begin
      hc("R9 offer_num", offer_num, m_num);
      hc("R2 offer_prio", offer_prio, m_prio);
      hc("R5 offer_server", offer_server, m_srv);
    end
    hc("R8 resend_busy", resend_busy, m_busy);
    hc("R5 peek_prio", peek_prio, mp[k]);
    hc("R5 peek_saved", peek_saved, ms[k]);
    hc("R5 peek_server", peek_server, msrv[k]);
    hc("R6 peek_status", peek_status, {mm[k], mr[k], mst[k], ma[k]});
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset(); else model_step();
    #2;
    if (!done) compare();
  end

  task automatic nx(); @(negedge clk); endtask
  task automatic pk(int i); peek_idx = IW'(i); #1; endtask
  task automatic cfg(int i, int s, int p, int sv);
    cfg_we = 1; cfg_idx = IW'(i); cfg_server = SRV_W'(s); cfg_prio = 8'(p); cfg_saved = 8'(sv);
    nx(); cfg_we = 0;
  endtask
  task automatic rej(int n); rej_valid = 1; rej_num = NUM_W'(n); nx(); rej_valid = 0; endtask
  task automatic eoi(int n); eoi_valid = 1; eoi_num = NUM_W'(n); nx(); eoi_valid = 0; endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog act=timeout exp=finished");
      finish_run();
    end
  end

  initial begin
    int cnt;
    bit seen;
    repeat (3) nx();
    rst_n = 1;
    // R1 reset state
    pk(0);
    hc("R1 prio", peek_prio, 255); hc("R1 saved", peek_saved, 255);
    hc("R1 server", peek_server, 0); hc("R1 status", peek_status, 0);
    hc("R1 offer_valid", offer_valid, 0); hc("R1 busy", resend_busy, 0);
    pk(5); hc("R1 status lvl", peek_status, 0); hc("R1 prio lvl", peek_prio, 255);
    // R3 masked message latches
    src_in[0] = 1; nx(); src_in[0] = 0; pk(0);
    hc("R3 masked pending", peek_status, 8);
    nx(); nx(); hc("R2 masked not offered", offer_valid, 0);
    // R5 unmask replays
    cfg(0, 3, 5, 7); pk(0);
    hc("R5 status", peek_status, 0); hc("R5 saved", peek_saved, 7); hc("R5 server", peek_server, 3);
    nx(); hc("R5 replay valid", offer_valid, 1); hc("R5 replay num", offer_num, 4096);
    hc("R5 replay prio", offer_prio, 5); hc("R5 replay server", offer_server, 3);
    // R3 immediate message
    cfg(1, 1, 3, 3); nx();
    src_in[1] = 1; nx(); src_in[1] = 0; nx();
    hc("R3 offer valid", offer_valid, 1); hc("R3 offer num", offer_num, 4097);
    // R4 level
    cfg(4, 0, 2, 2); nx();
    src_in[4] = 1; nx(); pk(4); hc("R4 status sent", peek_status, 3);
    nx(); hc("R4 offer num", offer_num, 4100); hc("R4 offer prio", offer_prio, 2);
    // R6 reject
    rej(4100); pk(4); hc("R6 status", peek_status, 5);
    nx(); nx(); nx(); hc("R4 steady no reoffer", offer_valid, 0);
    rej(9999); pk(4); hc("R6 out of range", peek_status, 5);
    pk(0); hc("R6 out of range other", peek_status, 0);
    // R8 resend
    resend_req = 1; nx(); resend_req = 0;
    cnt = 0;
    while (resend_busy && cnt < 100) begin cnt++; nx(); end
    hc("R8 busy cycles", cnt, N);
    pk(4); hc("R8 level resent", peek_status, 7);
    // R7 EOI
    eoi(4100); pk(4); hc("R7 level eoi", peek_status, 5);
    rej(4097); pk(1); hc("R6 msg reject", peek_status, 4);
    eoi(4097); pk(1); hc("R7 msg eoi no effect", peek_status, 4);
    resend_req = 1; nx(); resend_req = 0;
    seen = 0; cnt = 0;
    while ((resend_busy || offer_valid) && cnt < 100) begin
      if (offer_valid && offer_num == 4097) seen = 1;
      cnt++; nx();
    end
    hc("R8 msg reoffered", seen, 1);
    pk(1); hc("R8 rejected cleared", peek_status, 0);
    // R9 ordering and hold
    offer_ready = 0;
    cfg(2, 2, 9, 9); cfg(3, 3, 1, 1); nx();
    src_in[2] = 1; src_in[3] = 1; nx(); src_in[2] = 0; src_in[3] = 0; nx();
    hc("R9 lowest index first", offer_num, 4098);
    nx(); nx(); hc("R9 held", offer_num, 4098); hc("R9 held prio", offer_prio, 9);
    offer_ready = 1; nx(); hc("R9 next", offer_num, 4099);
    nx(); hc("R9 drained", offer_valid, 0);
    // R5 masking a queued source
    offer_ready = 0;
    src_in[2] = 1; src_in[3] = 1; nx(); src_in[2] = 0; src_in[3] = 0;
    cfg(3, 3, 255, 1);
    pk(3); hc("R5 cancel to pending", peek_status, 8);
    hc("R5 first offered", offer_num, 4098);
    offer_ready = 1; nx(); nx(); nx();
    hc("R5 cancelled not offered", offer_valid, 0);
    // R1 reset mid-run
    rst_n = 0; nx(); pk(4);
    hc("R1 mid status", peek_status, 0); hc("R1 mid prio", peek_prio, 255);
    hc("R1 mid valid", offer_valid, 0);
    rst_n = 1; nx();
    // random phase
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        if (LVL[i]) begin if ($urandom_range(0, 19) == 0) src_in[i] = ~src_in[i]; end
        else src_in[i] = ($urandom_range(0, 9) == 0);
      end
      cfg_we = ($urandom_range(0, 9) == 0);
      cfg_idx = IW'($urandom_range(0, N - 1));
      cfg_prio = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 7));
      cfg_saved = 8'($urandom_range(0, 255));
      cfg_server = SRV_W'($urandom_range(0, 255));
      rej_valid = ($urandom_range(0, 9) == 0);
      rej_num = NUM_W'(BASE + $urandom_range(0, N + 1));
      eoi_valid = ($urandom_range(0, 9) == 0);
      eoi_num = NUM_W'(BASE + $urandom_range(0, N + 1));
      resend_req = ($urandom_range(0, 29) == 0);
      offer_ready = ($urandom_range(0, 9) < 7);
      peek_idx = IW'($urandom_range(0, N - 1));
      nx();
    end
    cfg_we = 0; rej_valid = 0; eoi_valid = 0; resend_req = 0;
    nx();
    finish_run();
  end
endmodule